// File: doc/BRIEF.md
# Sync-Aligned Clamp Pulse Generator

This block turns a horizontal sync signal, already synchronized to the system clock and normalized so that high means active, into a clamp pulse. Downstream video clamping uses that pulse to restore the black level. A pulse can start on either the rising (leading) or the falling (trailing) sync transition. A direction bit selects which one. A polarity bit makes the pulse high-going or low-going. A 3-bit code sets its length in steps of four system clocks.

The sync input is sampled every clock and compared with the previous sample. When the selected transition is seen, a down-counter loads the length taken from the width code, and the output holds its active level while the counter is non-zero. If a new qualifying transition arrives during a pulse, the counter reloads from the code present at that moment. The output is otherwise at the rest level, which is the inverse of the selected polarity. All inputs are plain control pins with no handshake. There is no data stream and so no back-pressure.

Top module: `clamp_pulse_gen`

## Requirements
- R1: With `lead_sel_i` = 1, a 0-to-1 transition of `hsync_i` starts a pulse. The output takes its active level in the cycle after the clock edge that first samples `hsync_i` high. A 1-to-0 transition starts nothing.
- R2: With `lead_sel_i` = 0, a 1-to-0 transition of `hsync_i` starts a pulse, with the same one-cycle timing as R1. A 0-to-1 transition starts nothing.
- R3: With `pol_i` = 1 the active level of `clamp_o` is 1. With `pol_i` = 0 the active level is 0.
- R4: A pulse lasts exactly (`width_code_i` + 1) × 4 clocks, so code 0 gives 4 clocks and code 7 gives 32 clocks.
- R5: A qualifying transition during a pulse restarts the count, and the pulse ends a full width after the new transition.
- R6: Whenever no pulse is running, including while `rst_n` is low, `clamp_o` equals the inverse of `pol_i`.
- R7: The width code is captured only at the trigger. Changing `width_code_i` during a pulse does not change that pulse's length.
- R8: The first sample after reset release only establishes the reference level. A sync input that is already high when reset is released is not taken as a transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Synchronized, active-high horizontal sync |
| lead_sel_i | input | 1 | 1: trigger on rising sync edge; 0: on falling edge |
| pol_i | input | 1 | 1: high-going pulse; 0: low-going pulse |
| width_code_i | input | 3 | Pulse length code, length = (code+1)×4 clocks |
| clamp_o | output | 1 | Clamp pulse output |

## Verification
A sync transition that is driven before a clock edge shows up on `clamp_o` one clock later. It then stays at the active level for the coded number of clocks. Polarity changes act combinationally on the output. The bench changes inputs on the falling clock edge, begins sampling at the next falling edge and counts the consecutive samples at the active level. That count must match the coded width, or width plus the offset of the restart in the retrigger test. A transition that should be ignored must give a count of zero.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

  typedef enum logic {
    TRIG_TRAILING = 1'b0,
    TRIG_LEADING  = 1'b1
  } trig_edge_e;

  typedef enum logic [1:0] {
    SYNC_STEADY = 2'b00,
    SYNC_RISE   = 2'b01,
    SYNC_FALL   = 2'b10
  } sync_event_e;

endpackage

// File: rtl/clamp_edge_detect.sv
module clamp_edge_detect
  import clamp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic lead_sel_i,
  output logic primed_o,
  output logic trig_o
);

  logic        prev_q;
  logic        primed_q;
  sync_event_e evt;
  trig_edge_e  want;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= sync_i;
      primed_q <= 1'b1;
    end
  end

  always_comb begin
    evt = SYNC_STEADY;
    if (primed_q) begin
      if (sync_i && !prev_q)      evt = SYNC_RISE;
      else if (!sync_i && prev_q) evt = SYNC_FALL;
    end
  end

  assign want = trig_edge_e'(lead_sel_i);

  always_comb begin
    unique case (want)
      TRIG_LEADING:  trig_o = (evt == SYNC_RISE);
      TRIG_TRAILING: trig_o = (evt == SYNC_FALL);
      default:       trig_o = 1'b0;
    endcase
  end

  assign primed_o = primed_q;

endmodule

// File: rtl/clamp_width_timer.sv
module clamp_width_timer #(
  parameter int CODE_W = 3,
  parameter int STEP   = 4,
  localparam int MAX_LEN = (2 ** CODE_W) * STEP,
  localparam int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  cnt_o
);

  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_v;

  assign load_v = (CNT_W'(code_i) + CNT_W'(1)) * STEP_V;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (trig_i)          cnt_q <= load_v;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign active_o = (cnt_q != '0);
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/clamp_level_out.sv
module clamp_level_out (
  input  logic active_i,
  input  logic pol_i,
  output logic level_o
);

  assign level_o = active_i ? pol_i : ~pol_i;

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
  parameter int CODE_W = 3,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_i,
  input  logic              lead_sel_i,
  input  logic              pol_i,
  input  logic [CODE_W-1:0] width_code_i,
  output logic              clamp_o
);

  localparam int MAX_LEN = (2 ** CODE_W) * STEP;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             trig;
  logic             primed;
  logic             active;
  logic [CNT_W-1:0] cnt;

  clamp_edge_detect u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (hsync_i),
    .lead_sel_i (lead_sel_i),
    .primed_o   (primed),
    .trig_o     (trig)
  );

  clamp_width_timer #(
    .CODE_W (CODE_W),
    .STEP   (STEP)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig),
    .code_i   (width_code_i),
    .active_o (active),
    .cnt_o    (cnt)
  );

  clamp_level_out u_out (
    .active_i (active),
    .pol_i    (pol_i),
    .level_o  (clamp_o)
  );

endmodule

// File: rtl/clamp_pulse_chk.sv
module clamp_pulse_chk #(
  parameter int CODE_W = 3,
  parameter int STEP   = 4,
  localparam int MAX_LEN = (2 ** CODE_W) * STEP,
  localparam int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pol_i,
  input logic [CODE_W-1:0] width_code_i,
  input logic              clamp_o,
  input logic              trig,
  input logic              primed,
  input logic              active,
  input logic [CNT_W-1:0]  cnt
);

  // R1, R2: a trigger makes the pulse active in the next cycle
  assert_pulse_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> active);

  // R4: a fresh load equals the coded length
  assert_load_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (int'(cnt) == (int'($past(width_code_i)) + 1) * STEP));

  // R4: the counter never exceeds the maximum length
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= MAX_LEN);

  // R7: with no trigger, a running pulse only counts down
  assert_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !trig) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R3: active level follows the polarity bit
  assert_active_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (clamp_o == pol_i));

  // R6: idle level is the inverse of the polarity bit
  assert_rest_level_R6: assert property (@(posedge clk)
    !active |-> (clamp_o == !pol_i));

  // R8: nothing triggers before the reference sample is taken
  assert_no_early_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !trig);

endmodule

bind clamp_pulse_gen clamp_pulse_chk #(
  .CODE_W (CODE_W),
  .STEP   (STEP)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pol_i        (pol_i),
  .width_code_i (width_code_i),
  .clamp_o      (clamp_o),
  .trig         (trig),
  .primed       (primed),
  .active       (active),
  .cnt          (cnt)
);

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {lead_sel, pol, code}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b1_1_000, 5'b1_0_011, 5'b0_1_111, 5'b0_0_001,
    5'b1_1_111, 5'b0_1_000, 5'b1_0_101, 5'b0_0_110
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_i = 1'b0;
  logic       lead_sel_i = 1'b1;
  logic       pol_i = 1'b1;
  logic [2:0] width_code_i = 3'd0;
  logic       clamp_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clamp_pulse_gen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hsync_i      (hsync_i),
    .lead_sel_i   (lead_sel_i),
    .pol_i        (pol_i),
    .width_code_i (width_code_i),
    .clamp_o      (clamp_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts consecutive active samples starting one clock after the drive
  task automatic measure(output int len);
    len = 0;
    @(negedge clk);
    while (clamp_o == pol_i && len < 80) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int len;
    int w;
    // R6: rest level during reset for both polarities
    idle(2);
    pol_i = 1'b1;
    #1 check("R6 reset rest pol1", clamp_o, 0);
    pol_i = 1'b0;
    #1 check("R6 reset rest pol0", clamp_o, 1);
    hsync_i = 1'b1; idle(2); hsync_i = 1'b0; idle(2);
    check("R6 sync toggling in reset", clamp_o, 1);

    // R8: sync high at reset release is not an edge
    pol_i = 1'b1; lead_sel_i = 1'b1; hsync_i = 1'b1;
    idle(1); rst_n = 1'b1;
    measure(len);
    check("R8 high at release no pulse", len, 0);
    hsync_i = 1'b0; measure(len);
    check("R1 falling ignored in leading mode", len, 0);
    idle(5);

    // table walk: R1 R2 R3 R4
    for (int v = 0; v < NVEC; v++) begin
      lead_sel_i   = VEC[v][4];
      pol_i        = VEC[v][3];
      width_code_i = VEC[v][2:0];
      w = (int'(VEC[v][2:0]) + 1) * 4;
      hsync_i = 1'b0; idle(40);
      check("R6 rest level", clamp_o, !pol_i);
      hsync_i = 1'b1; measure(len);
      check(lead_sel_i ? "R1 R4 leading width" : "R2 leading ignored",
            len, lead_sel_i ? w : 0);
      idle(40);
      hsync_i = 1'b0; measure(len);
      check(lead_sel_i ? "R1 trailing ignored" : "R2 R4 trailing width",
            len, lead_sel_i ? 0 : w);
      check("R3 R6 level after pulse", clamp_o, !pol_i);
      idle(40);
    end

    // R5: retrigger 4 clocks into a pulse, code 0 (4 clocks) -> 8 total
    lead_sel_i = 1'b1; pol_i = 1'b1; width_code_i = 3'd0;
    hsync_i = 1'b0; idle(10);
    hsync_i = 1'b1;            // drive at negedge 0
    len = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (clamp_o == pol_i) len++;
      if (i == 3) hsync_i = 1'b0;
      if (i == 4) hsync_i = 1'b1;
    end
    check("R5 retrigger extends pulse", len, 8);

    // R7: code change mid-pulse does not alter length
    width_code_i = 3'd7; hsync_i = 1'b0; idle(10);
    hsync_i = 1'b1;
    len = 0;
    @(negedge clk);
    while (clamp_o == pol_i && len < 80) begin
      len++;
      if (len == 1) width_code_i = 3'd0;
      @(negedge clk);
    end
    check("R7 width captured at trigger", len, 32);

    // R3: polarity flip while idle moves rest level
    pol_i = 1'b0; #1;
    check("R3 R6 rest follows polarity", clamp_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule